// File: doc/BRIEF.md
# Reset and Sleep Wake-up Controller

This block gathers the reset causes of a small microcontroller core and turns them into one stretched core reset. Three causes are recognised: a power-on pulse, an active-low external reset pin, and a watchdog timeout that counts only while the watchdog is enabled. After the last cause has gone away, the core reset is held for a start-up window of a parameterised number of clock cycles. This window covers the oscillator settling time, about 18 ms on a real part. During the window the block asks for the program counter to be preset to all ones and for the I/O pins to float as inputs. It also keeps the watchdog counter and its prescaler cleared. Power-on-only clear strobes are raised only when power-on was among the causes.

The block also tracks the low-power state. A sleep instruction strobe puts the core to sleep. A mode-select bit picks the basic sleep or the deeper second sleep mode. On sleep entry the watchdog gets a one-cycle clear if it is enabled, and it keeps counting. The external reset pin or an enabled watchdog timeout wakes the core, and waking always goes through the full start-up window. Two status flags, T and P, record the cause of the last reset or wake-up. The block also supplies the fixed reset values that the surrounding control registers load.

Top module: `rst_wake_ctrl`

## Requirements
- R1: A power-on pulse (`por_i`=1), a low external reset pin (`ext_rst_ni`=0) or a watchdog timeout with `wdt_en_i`=1 raises `core_rst_o` in the cycle after it is sampled. A timeout while `wdt_en_i`=0 has no effect.
- R2: `core_rst_o`, `pc_preset_o` and `io_hiz_o` stay high for exactly `OST_CYCLES` cycles counted from the last cycle in which a reset cause was sampled. This also holds after `rst_ni` is released, which counts as power-on.
- R3: A reset cause that arrives while the start-up window is running restarts the window from zero.
- R4: `wdt_clr_o` is high in every cycle in which `core_rst_o` is high. It is also high for one cycle after a sleep entry, but only when `wdt_en_i`=1.
- R5: `por_clr_o` is high during a start-up window only if power-on (or `rst_ni`) started that window or restarted it. An external or watchdog reset alone leaves it low. A later non-power-on restart inside the window keeps it high.
- R6: The register reset values are constant outputs:
  - control register: 8'hBF, which is all ones except bit 6
  - wake-up disable register: 8'hFF
  - mode register: 8'h31, which sets bits 0, 4 and 5 and clears bits 1, 2, 3, 6 and 7
  - clear mask for the interrupt status and enable registers: 8'h09, which clears bits 0 and 3
- R7: `sleep_i` enters sleep (`sleep_o`=1 in the next cycle) only while out of reset and awake. In any other state it is ignored: neither the sleep mode, nor the flags, nor `wdt_clr_o` change.
- R8: `sleep2_o` is 1 while asleep if `slp_ctrl_i` was 0 when the sleep was entered. It is 0 if `slp_ctrl_i` was 1.
- R9: While asleep, a low external reset pin or an enabled watchdog timeout clears `sleep_o` and `sleep2_o` and starts a full start-up window in the next cycle.
- R10: Flags `{flag_t_o, flag_p_o}` are set as follows:
  - power-on or `rst_ni`: 1,1
  - sleep entry: 1,0
  - enabled watchdog timeout: T=0 with P unchanged
  - external reset: both unchanged
  - power-on together with a watchdog timeout: power-on wins

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset, treated as power-on |
| por_i | input | 1 | Power-on reset pulse, synchronous, active high |
| ext_rst_ni | input | 1 | External reset pin, active low, synchronised |
| wdt_timeout_i | input | 1 | Watchdog timeout strobe |
| wdt_en_i | input | 1 | Watchdog enable |
| sleep_i | input | 1 | Sleep instruction strobe |
| slp_ctrl_i | input | 1 | Sleep control bit, 0 selects the second sleep mode |
| core_rst_o | output | 1 | Stretched core reset |
| pc_preset_o | output | 1 | Request to preset the program counter to all ones |
| io_hiz_o | output | 1 | Force all I/O pins to input mode |
| wdt_clr_o | output | 1 | Clear for the watchdog counter and prescaler |
| por_clr_o | output | 1 | Power-on-only clear for the status and select bits |
| flag_t_o | output | 1 | Cause flag T |
| flag_p_o | output | 1 | Cause flag P |
| sleep_o | output | 1 | Core is asleep |
| sleep2_o | output | 1 | Core is in the second sleep mode |
| ctrl_rst_val_o | output | 8 | Reset value of the control register |
| wake_dis_rst_val_o | output | 8 | Reset value of the wake-up disable register |
| mode_rst_val_o | output | 8 | Reset value of the mode register |
| irq_clr_mask_o | output | 8 | Bits cleared in the interrupt status and enable registers |

## Verification
A wrong start-up counter shows as a `core_rst_o` window that is too short or too long. It becomes visible `OST_CYCLES` cycles after the last cause, so every window is measured to the exact cycle, including windows that were restarted. A stale power-on or sleep state shows within one cycle: `por_clr_o` or `sleep_o` goes wrong right after the event. A wrong flag update shows in the flags, which are sampled one cycle after each cause, including the simultaneous and ignored cases.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  localparam int unsigned REG_W = 8;
  localparam logic [REG_W-1:0] CTRL_RST_VAL     = 8'hBF;
  localparam logic [REG_W-1:0] WAKE_DIS_RST_VAL = 8'hFF;
  localparam logic [REG_W-1:0] MODE_RST_VAL     = 8'h31;
  localparam logic [REG_W-1:0] IRQ_CLR_MASK     = 8'h09;

  typedef struct packed {
    logic por;
    logic wdt;
    logic ext;
    logic any;
  } rst_ev_t;
endpackage

// File: rtl/rwc_event_merge.sv
module rwc_event_merge
  import rwc_pkg::*;
(
  input  logic    por_i,
  input  logic    ext_rst_ni,
  input  logic    wdt_timeout_i,
  input  logic    wdt_en_i,
  output rst_ev_t ev_o
);
  always_comb begin
    ev_o.por = por_i;
    ev_o.ext = ~ext_rst_ni;
    ev_o.wdt = wdt_timeout_i & wdt_en_i;
    ev_o.any = ev_o.por | ev_o.ext | ev_o.wdt;
  end
endmodule

// File: rtl/rwc_ost_timer.sv
module rwc_ost_timer #(
  parameter int unsigned OST_CYCLES = 2250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic por_i,
  output logic busy_o,
  output logic por_clr_o
);
  localparam int unsigned CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          por_seen_q;
  logic          done;

  assign done = busy_q && !start_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    por_seen_q <= 1'b1;
    else if (por_i) por_seen_q <= 1'b1;
    else if (done)  por_seen_q <= 1'b0;
  end

  assign busy_o    = busy_q;
  assign por_clr_o = busy_q & por_seen_q;

  // R3: any new cause restarts the window
  assert_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && cnt_q == '0));
  // R2: window closes right after its final count
  assert_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && cnt_q == LAST) |=> !busy_q);
  // R5: non power-on start never raises the power-on clear
  assert_por_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !por_i && !busy_q) |=> !por_clr_o);
endmodule

// File: rtl/rwc_sleep_ctrl.sv
module rwc_sleep_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  input  logic slp_ctrl_i,
  input  logic wdt_en_i,
  input  logic wake_i,
  input  logic busy_i,
  output logic sleep_go_o,
  output logic asleep_o,
  output logic deep_o,
  output logic slp_wdt_clr_o
);
  logic asleep_q, deep_q, clr_q;

  assign sleep_go_o = sleep_i & ~busy_i & ~asleep_q & ~wake_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asleep_q <= 1'b0;
      deep_q   <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      clr_q <= sleep_go_o & wdt_en_i;
      if (wake_i) begin
        asleep_q <= 1'b0;
        deep_q   <= 1'b0;
      end else if (sleep_go_o) begin
        asleep_q <= 1'b1;
        deep_q   <= ~slp_ctrl_i;
      end
    end
  end

  assign asleep_o      = asleep_q;
  assign deep_o        = deep_q & asleep_q;
  assign slp_wdt_clr_o = clr_q;

  // R7: never asleep while the start-up window runs
  assert_no_sleep_in_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !asleep_q);
  // R8: sleep mode held while asleep
  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_q && !wake_i) |=> $stable(deep_q));
endmodule

// File: rtl/rwc_cause_flags.sv
module rwc_cause_flags
  import rwc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  rst_ev_t ev_i,
  input  logic    sleep_go_i,
  output logic    flag_t_o,
  output logic    flag_p_o
);
  logic t_q, p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= 1'b1;
      p_q <= 1'b1;
    end else if (ev_i.por) begin
      t_q <= 1'b1;
      p_q <= 1'b1;
    end else if (ev_i.wdt) begin
      t_q <= 1'b0;
    end else if (sleep_go_i) begin
      t_q <= 1'b1;
      p_q <= 1'b0;
    end
  end

  assign flag_t_o = t_q;
  assign flag_p_o = p_q;

  // R10: power-on wins over every other cause
  assert_por_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.por |=> (t_q && p_q));
  // R10: external reset alone leaves flags alone
  assert_ext_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.ext && !ev_i.por && !ev_i.wdt) |=> ($stable(t_q) && $stable(p_q)));
endmodule

// File: rtl/rst_wake_ctrl.sv
module rst_wake_ctrl
  import rwc_pkg::*;
#(
  parameter int unsigned OST_CYCLES = 2250000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_i,
  input  logic             ext_rst_ni,
  input  logic             wdt_timeout_i,
  input  logic             wdt_en_i,
  input  logic             sleep_i,
  input  logic             slp_ctrl_i,
  output logic             core_rst_o,
  output logic             pc_preset_o,
  output logic             io_hiz_o,
  output logic             wdt_clr_o,
  output logic             por_clr_o,
  output logic             flag_t_o,
  output logic             flag_p_o,
  output logic             sleep_o,
  output logic             sleep2_o,
  output logic [REG_W-1:0] ctrl_rst_val_o,
  output logic [REG_W-1:0] wake_dis_rst_val_o,
  output logic [REG_W-1:0] mode_rst_val_o,
  output logic [REG_W-1:0] irq_clr_mask_o
);
  rst_ev_t ev;
  logic    busy, sleep_go, slp_clr;

  rwc_event_merge u_merge (
    .por_i(por_i), .ext_rst_ni(ext_rst_ni), .wdt_timeout_i(wdt_timeout_i),
    .wdt_en_i(wdt_en_i), .ev_o(ev)
  );

  rwc_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(ev.any), .por_i(ev.por),
    .busy_o(busy), .por_clr_o(por_clr_o)
  );

  rwc_sleep_ctrl u_sleep (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .slp_ctrl_i(slp_ctrl_i),
    .wdt_en_i(wdt_en_i), .wake_i(ev.any), .busy_i(busy), .sleep_go_o(sleep_go),
    .asleep_o(sleep_o), .deep_o(sleep2_o), .slp_wdt_clr_o(slp_clr)
  );

  rwc_cause_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(ev), .sleep_go_i(sleep_go),
    .flag_t_o(flag_t_o), .flag_p_o(flag_p_o)
  );

  assign core_rst_o  = busy;
  assign pc_preset_o = busy;
  assign io_hiz_o    = busy;
  assign wdt_clr_o   = busy | slp_clr;

  assign ctrl_rst_val_o     = CTRL_RST_VAL;
  assign wake_dis_rst_val_o = WAKE_DIS_RST_VAL;
  assign mode_rst_val_o     = MODE_RST_VAL;
  assign irq_clr_mask_o     = IRQ_CLR_MASK;

  // R1: a disabled watchdog timeout cannot start a reset
  assert_ignore_wdt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_o && !por_i && ext_rst_ni && !wdt_en_i) |=> !core_rst_o);
  // R4: sleep entry with the watchdog on clears it
  assert_sleep_wdt_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !core_rst_o && !sleep_o && !ev.any && wdt_en_i) |=> (wdt_clr_o && sleep_o));
  // R9: wake-up forces a full reset
  assert_wake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && ev.any) |=> (!sleep_o && !sleep2_o && core_rst_o));
endmodule

// File: tb/rst_wake_ctrl_tb.sv
module rst_wake_ctrl_tb;
  localparam int unsigned OST = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 1'b0, ext_n = 1'b1, wdt_to = 1'b0, wdt_en = 1'b0;
  logic slp = 1'b0, slp_ctrl = 1'b1;
  logic core_rst, pc_preset, io_hiz, wdt_clr, por_clr, ft, fp, sleep_s, sleep2_s;
  logic [7:0] ctrl_v, wake_v, mode_v, irq_m;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_wake_ctrl #(.OST_CYCLES(OST)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .ext_rst_ni(ext_n),
    .wdt_timeout_i(wdt_to), .wdt_en_i(wdt_en), .sleep_i(slp), .slp_ctrl_i(slp_ctrl),
    .core_rst_o(core_rst), .pc_preset_o(pc_preset), .io_hiz_o(io_hiz),
    .wdt_clr_o(wdt_clr), .por_clr_o(por_clr), .flag_t_o(ft), .flag_p_o(fp),
    .sleep_o(sleep_s), .sleep2_o(sleep2_s), .ctrl_rst_val_o(ctrl_v),
    .wake_dis_rst_val_o(wake_v), .mode_rst_val_o(mode_v), .irq_clr_mask_o(irq_m)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // counts sampled cycles with core reset high, starting at the current negedge
  task automatic meas(output int n);
    n = 0;
    while (core_rst && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // all tasks enter and leave at a negedge
  task automatic pulse(input logic p, input logic e, input logic w, input logic s);
    por = p; ext_n = ~e; wdt_to = w; slp = s;
    @(negedge clk);
    por = 1'b0; ext_n = 1'b1; wdt_to = 1'b0; slp = 1'b0;
  endtask

  task automatic t_reset;
    int n;
    check("R2 core_rst after rst_ni", core_rst, 1);
    check("R2 pc_preset", pc_preset, 1);
    check("R2 io_hiz", io_hiz, 1);
    check("R5 por_clr after rst_ni", por_clr, 1);
    check("R10 flags after rst_ni", {ft, fp}, 2'b11);
    check("R7 awake after rst_ni", sleep_s, 0);
    check("R4 wdt_clr in reset", wdt_clr, 1);
    meas(n);
    check("R2 stretch after rst_ni", n, OST);
    check("R5 por_clr ends", por_clr, 0);
  endtask

  task automatic t_consts;
    check("R6 ctrl value", ctrl_v, 8'hBF);
    check("R6 wake disable value", wake_v, 8'hFF);
    check("R6 mode value", mode_v, 8'h31);
    check("R6 irq mask", irq_m, 8'h09);
  endtask

  task automatic t_ext;
    int n;
    pulse(0, 1, 0, 0);
    check("R1 ext reset", core_rst, 1);
    check("R5 no por_clr on ext", por_clr, 0);
    check("R10 ext keeps flags", {ft, fp}, 2'b11);
    meas(n);
    check("R2 ext stretch", n, OST);
  endtask

  task automatic t_wdt;
    int n;
    wdt_en = 1'b0;
    pulse(0, 0, 1, 0);
    check("R1 disabled wdt ignored", core_rst, 0);
    @(negedge clk);
    check("R1 disabled wdt still idle", core_rst, 0);
    wdt_en = 1'b1;
    pulse(0, 0, 1, 0);
    check("R1 enabled wdt reset", core_rst, 1);
    check("R4 wdt_clr in wdt reset", wdt_clr, 1);
    check("R10 wdt flags", {ft, fp}, 2'b01);
    check("R5 no por_clr on wdt", por_clr, 0);
    meas(n);
    check("R2 wdt stretch", n, OST);
    check("R4 wdt_clr released", wdt_clr, 0);
  endtask

  task automatic t_restart;
    int n;
    pulse(1, 0, 0, 0);
    check("R10 por flags", {ft, fp}, 2'b11);
    repeat (9) @(negedge clk);
    pulse(0, 1, 0, 0);
    check("R5 por_clr kept on restart", por_clr, 1);
    meas(n);
    check("R3 restarted stretch", n, OST);
  endtask

  task automatic t_sleep1;
    int n;
    wdt_en = 1'b1; slp_ctrl = 1'b1;
    pulse(0, 0, 0, 1);
    check("R7 sleep entered", sleep_s, 1);
    check("R8 basic mode", sleep2_s, 0);
    check("R4 wdt_clr on sleep", wdt_clr, 1);
    check("R10 sleep flags", {ft, fp}, 2'b10);
    check("R7 no reset on sleep", core_rst, 0);
    @(negedge clk);
    check("R4 sleep wdt_clr one cycle", wdt_clr, 0);
    slp_ctrl = 1'b0;
    pulse(0, 0, 0, 1);
    check("R7 sleep while asleep ignored", sleep2_s, 0);
    check("R7 no wdt_clr while asleep", wdt_clr, 0);
    slp_ctrl = 1'b1;
    pulse(0, 0, 1, 0);
    check("R9 wdt wakes", sleep_s, 0);
    check("R9 wake resets", core_rst, 1);
    check("R10 wdt wake flags", {ft, fp}, 2'b00);
    meas(n);
    check("R9 wake stretch", n, OST);
  endtask

  task automatic t_sleep2;
    int n;
    wdt_en = 1'b0; slp_ctrl = 1'b0;
    pulse(0, 0, 0, 1);
    check("R8 second mode", {sleep_s, sleep2_s}, 2'b11);
    check("R4 no wdt_clr when disabled", wdt_clr, 0);
    check("R10 sleep flags mode2", {ft, fp}, 2'b10);
    slp_ctrl = 1'b1;
    pulse(0, 1, 0, 0);
    check("R9 ext wakes", {sleep_s, sleep2_s}, 2'b00);
    check("R9 ext wake resets", core_rst, 1);
    check("R10 ext wake flags", {ft, fp}, 2'b10);
    meas(n);
    check("R9 ext wake stretch", n, OST);
  endtask

  task automatic t_sleep_in_reset;
    int n;
    wdt_en = 1'b1;
    pulse(1, 0, 0, 0);
    @(negedge clk);
    pulse(0, 0, 0, 1);
    check("R7 sleep in reset ignored", sleep_s, 0);
    check("R7 flags kept in reset", {ft, fp}, 2'b11);
    meas(n);
    check("R7 stretch unaffected", n, OST - 2);
  endtask

  task automatic t_priority;
    int n;
    wdt_en = 1'b1;
    pulse(1, 0, 1, 0);
    check("R10 por beats wdt", {ft, fp}, 2'b11);
    check("R5 por_clr with wdt", por_clr, 1);
    meas(n);
  endtask

  task automatic t_held;
    int n;
    ext_n = 1'b0;
    repeat (30) @(negedge clk);
    check("R2 held while pin low", core_rst, 1);
    ext_n = 1'b1;
    meas(n);
    check("R2 stretch after pin release", n, OST);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_consts();
    t_ext();
    t_wdt();
    t_restart();
    t_sleep1();
    t_sleep2();
    t_sleep_in_reset();
    t_priority();
    t_held();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule